// File: doc/BRIEF.md
# Simple-Mode DMA Transfer Engine

This block is the datapath controller of a single DMA channel. When it receives a start pulse, it moves the bytes of one source descriptor to the destination. It reads through a memory read port and writes through a memory write port. Each port carries an address, a byte length and one data beat, and each has a ready handshake. A one-bus-word staging register sits between the two ports. Every read chunk is therefore at most one bus word long, and the next read waits until the write side has drained the previous chunk.

The engine has three transfer modes. Read-write copies source to destination. Write-only fills the destination with a pattern taken from a 128-bit pattern input. Read-only reads the source and writes nothing. Bursts can be incrementing or fixed-address.

In scatter-gather operation the engine always copies with incrementing addresses. A source transfer that crosses the end of a destination descriptor is split at that boundary. The engine then asks an outside fetcher for the next destination descriptor over a request/acknowledge handshake.

A running byte total, cleared by writing ones, counts every chunk. The engine also produces one-cycle pulses for transfer done, source done and destination done.

Top module: `dma_simple_engine`

## Requirements
- R1: The `xfer_mode` encoding is 0 read-write, 1 write-only and 2 read-only; the value 3 behaves as read-write.
- R2: The `burst_incr` encoding is 1 incrementing and 0 fixed. With fixed bursts the read and write addresses stay at their start values for the whole transfer. With incrementing bursts each address advances by the length of every accepted access.
- R3: Each read chunk is min(remaining source bytes, BUS_W/8). A read request holds its address and length until `rd_ready`. No read and write are requested in the same cycle.
- R4: In write-only mode no read is issued and the byte count is `dst_size`; `src_size` is not used. Each write carries the pattern with byte j taken from `fill_pattern[8j+7:8j]`, starting from byte 0 in every chunk.
- R5: In read-only mode the source is read but no write is issued.
- R6: When `sg_mode` is 0 and the mode is not write-only, `dst_size` is ignored and exactly `src_size` bytes are written.
- R7: When `sg_mode` is 1, the mode and burst inputs are ignored and the transfer runs as an incrementing read-write copy.
- R8: When `sg_mode` is 1, each write is min(buffered bytes, remaining destination bytes). When the destination runs out while data is still pending, `dsc_req` stays high until `dsc_ack`. On `dsc_ack` the engine loads `dsc_addr`, `dsc_size` and `dsc_intr`, and a loaded size of 0 makes it request again.
- R9: `dst_done` pulses for one cycle when a write brings the remaining destination count to zero and the current destination interrupt bit is set.
- R10: `total_bytes` (32 bits) adds the length of every chunk. On the same edge, bits set in `total_clr` are cleared first and the chunk length is added afterwards.
- R11: `done` pulses for one cycle after the last chunk completes, and `src_done` pulses with it when `src_intr` was set at start. A start with a byte count of 0 raises `done` on the first edge after start and makes no access.
- R12: After reset, `busy`, the request outputs, the pulses and `total_bytes` are 0. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| sg_mode | input | 1 | Scatter-gather operation: forces incrementing read-write |
| xfer_mode | input | 2 | 0 read-write, 1 write-only, 2 read-only |
| burst_incr | input | 1 | 1 incrementing, 0 fixed address |
| src_addr | input | ADDR_W | Source start address |
| src_size | input | SIZE_W | Source byte count |
| src_intr | input | 1 | Pulse src_done at the end |
| dst_addr | input | ADDR_W | Destination start address |
| dst_size | input | SIZE_W | Destination byte count |
| dst_intr | input | 1 | Pulse dst_done when the destination empties |
| fill_pattern | input | 128 | Pattern for write-only mode |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_len | output | LEN_W | Read length in bytes |
| rd_ready | input | 1 | Read accepted, rd_data valid |
| rd_data | input | BUS_W | Read data, byte 0 in bits 7:0 |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_len | output | LEN_W | Write length in bytes |
| wr_data | output | BUS_W | Write data, byte 0 in bits 7:0 |
| wr_ready | input | 1 | Write accepted |
| dsc_req | output | 1 | Next destination descriptor wanted |
| dsc_ack | input | 1 | Descriptor fields valid |
| dsc_addr | input | ADDR_W | Next destination address |
| dsc_size | input | SIZE_W | Next destination byte count |
| dsc_intr | input | 1 | Next destination interrupt bit |
| total_clr | input | 32 | Write-one-to-clear mask for the total |
| total_bytes | output | 32 | Running byte total |
| done | output | 1 | Transfer finished pulse |
| src_done | output | 1 | Source descriptor done pulse |
| dst_done | output | 1 | Destination descriptor done pulse |

## Verification
The bench builds the engine with BUS_W=64, ADDR_W=12 and SIZE_W=10. An 8-byte beat lets transfers of 5 to 24 bytes reach the full-word chunks, the short tail chunks and unaligned starts. The 4 KiB address space is small enough for the bench to mirror the whole destination as a byte array and compare every written byte against the source or the pattern. A scatter-gather run uses a 6-byte first destination inside a 20-byte source, so the split-at-boundary path, the descriptor handshake and a second dst_done all happen. Stalling ready patterns hold requests pending over several cycles.

// File: rtl/dma_se_pkg.sv
package dma_se_pkg;
    localparam logic [1:0] MODE_RW = 2'd0;
    localparam logic [1:0] MODE_WO = 2'd1;
    localparam logic [1:0] MODE_RO = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DREQ  = 2'd3
    } eng_st_e;
endpackage

// File: rtl/dma_se_chunk.sv
// Chunk length: the smaller of a remaining count and a cap.
module dma_se_chunk #(
    parameter int SIZE_W = 30,
    parameter int LEN_W  = 4
) (
    input  logic [SIZE_W-1:0] remain,
    input  logic [LEN_W-1:0]  cap,
    output logic [LEN_W-1:0]  len
);
    always_comb begin
        if (remain < SIZE_W'(cap)) len = remain[LEN_W-1:0];
        else                       len = cap;
    end
endmodule

// File: rtl/dma_se_total.sv
// Running byte total with write-one-to-clear mask; clear applies before add.
module dma_se_total #(
    parameter int TOTAL_W = 32,
    parameter int LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [LEN_W-1:0]   add_len,
    input  logic [TOTAL_W-1:0] clr,
    output logic [TOTAL_W-1:0] total
);
    logic [TOTAL_W-1:0] total_d, total_q;

    always_comb begin
        total_d = total_q & ~clr;
        if (add_en) total_d = total_d + TOTAL_W'(add_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

    assign total = total_q;
endmodule

// File: rtl/dma_simple_engine.sv
module dma_simple_engine
    import dma_se_pkg::*;
#(
    parameter int BUS_W   = 64,
    parameter int ADDR_W  = 48,
    parameter int SIZE_W  = 30,
    parameter int TOTAL_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      sg_mode,
    input  logic [1:0]                xfer_mode,
    input  logic                      burst_incr,
    input  logic [ADDR_W-1:0]         src_addr,
    input  logic [SIZE_W-1:0]         src_size,
    input  logic                      src_intr,
    input  logic [ADDR_W-1:0]         dst_addr,
    input  logic [SIZE_W-1:0]         dst_size,
    input  logic                      dst_intr,
    input  logic [127:0]              fill_pattern,
    output logic                      busy,
    output logic                      rd_valid,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic [$clog2(BUS_W/8):0]  rd_len,
    input  logic                      rd_ready,
    input  logic [BUS_W-1:0]          rd_data,
    output logic                      wr_valid,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [$clog2(BUS_W/8):0]  wr_len,
    output logic [BUS_W-1:0]          wr_data,
    input  logic                      wr_ready,
    output logic                      dsc_req,
    input  logic                      dsc_ack,
    input  logic [ADDR_W-1:0]         dsc_addr,
    input  logic [SIZE_W-1:0]         dsc_size,
    input  logic                      dsc_intr,
    input  logic [TOTAL_W-1:0]        total_clr,
    output logic [TOTAL_W-1:0]        total_bytes,
    output logic                      done,
    output logic                      src_done,
    output logic                      dst_done
);
    localparam int BEAT_B = BUS_W / 8;
    localparam int LEN_W  = $clog2(BEAT_B) + 1;

    typedef struct packed {
        eng_st_e           st;
        logic [1:0]        mode;
        logic              incr;
        logic              src_intr;
        logic              dst_intr;
        logic [ADDR_W-1:0] src_ptr;
        logic [SIZE_W-1:0] src_rem;
        logic [ADDR_W-1:0] dst_ptr;
        logic [SIZE_W-1:0] dst_rem;
        logic [BUS_W-1:0]  buf_w;
        logic [LEN_W-1:0]  buf_len;
        logic              done;
        logic              src_done;
        logic              dst_done;
    } eng_t;

    eng_t r_d, r_q;

    logic [LEN_W-1:0]  rd_chunk, wr_chunk;
    logic              add_en;
    logic [LEN_W-1:0]  add_len;
    logic [1:0]        start_mode;
    logic [SIZE_W-1:0] start_cnt, nx_src, nx_dst;
    logic [LEN_W-1:0]  nx_buf;

    dma_se_chunk #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) rd_len_i (
        .remain(r_q.src_rem), .cap(LEN_W'(BEAT_B)), .len(rd_chunk));

    dma_se_chunk #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) wr_len_i (
        .remain(r_q.dst_rem), .cap(r_q.buf_len), .len(wr_chunk));

    dma_se_total #(.TOTAL_W(TOTAL_W), .LEN_W(LEN_W)) total_i (
        .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_len(add_len),
        .clr(total_clr), .total(total_bytes));

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.src_done = 1'b0;
        r_d.dst_done = 1'b0;
        add_en       = 1'b0;
        add_len      = rd_chunk;
        nx_src       = r_q.src_rem - SIZE_W'(rd_chunk);
        nx_dst       = r_q.dst_rem - SIZE_W'(wr_chunk);
        nx_buf       = r_q.buf_len - wr_chunk;

        // Scatter-gather forces read-write; code 3 falls back to read-write.
        if (sg_mode || xfer_mode == 2'd3) start_mode = MODE_RW;
        else                             start_mode = xfer_mode;
        start_cnt = (start_mode == MODE_WO) ? dst_size : src_size;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.mode     = start_mode;
                    r_d.incr     = sg_mode | burst_incr;
                    r_d.src_intr = src_intr;
                    r_d.dst_intr = dst_intr;
                    r_d.src_ptr  = src_addr;
                    r_d.dst_ptr  = dst_addr;
                    r_d.src_rem  = start_cnt;
                    r_d.dst_rem  = (sg_mode || start_mode == MODE_WO) ? dst_size : start_cnt;
                    if (start_cnt == '0) begin
                        r_d.done     = 1'b1;
                        r_d.src_done = src_intr;
                    end else begin
                        r_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (r_q.mode == MODE_WO || rd_ready) begin
                    add_en      = 1'b1;
                    r_d.src_rem = nx_src;
                    r_d.buf_len = rd_chunk;
                    r_d.buf_w   = (r_q.mode == MODE_WO) ? fill_pattern[BUS_W-1:0] : rd_data;
                    if (r_q.incr && r_q.mode != MODE_WO)
                        r_d.src_ptr = r_q.src_ptr + ADDR_W'(rd_chunk);
                    if (r_q.mode == MODE_RO) begin
                        if (nx_src == '0) begin
                            r_d.st       = ST_IDLE;
                            r_d.done     = 1'b1;
                            r_d.src_done = r_q.src_intr;
                        end
                    end else begin
                        r_d.st = (r_q.dst_rem == '0) ? ST_DREQ : ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    r_d.buf_w   = r_q.buf_w >> {wr_chunk, 3'b000};
                    r_d.buf_len = nx_buf;
                    r_d.dst_rem = nx_dst;
                    if (r_q.incr) r_d.dst_ptr = r_q.dst_ptr + ADDR_W'(wr_chunk);
                    r_d.dst_done = (nx_dst == '0) && r_q.dst_intr;
                    if (nx_buf == '0) begin
                        if (r_q.src_rem == '0) begin
                            r_d.st       = ST_IDLE;
                            r_d.done     = 1'b1;
                            r_d.src_done = r_q.src_intr;
                        end else begin
                            r_d.st = ST_READ;
                        end
                    end else if (nx_dst == '0) begin
                        r_d.st = ST_DREQ;
                    end
                end
            end
            ST_DREQ: begin
                if (dsc_ack) begin
                    r_d.dst_ptr  = dsc_addr;
                    r_d.dst_rem  = dsc_size;
                    r_d.dst_intr = dsc_intr;
                    r_d.st       = (dsc_size == '0) ? ST_DREQ : ST_WRITE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign rd_valid = (r_q.st == ST_READ) && (r_q.mode != MODE_WO);
    assign rd_addr  = r_q.src_ptr;
    assign rd_len   = rd_chunk;
    assign wr_valid = (r_q.st == ST_WRITE);
    assign wr_addr  = r_q.dst_ptr;
    assign wr_len   = wr_chunk;
    assign wr_data  = r_q.buf_w;
    assign dsc_req  = (r_q.st == ST_DREQ);
    assign done     = r_q.done;
    assign src_done = r_q.src_done;
    assign dst_done = r_q.dst_done;
endmodule

// File: rtl/dma_simple_engine_chk.sv
module dma_simple_engine_chk #(
    parameter int ADDR_W  = 48,
    parameter int BUS_W   = 64,
    parameter int LEN_W   = 4,
    parameter int TOTAL_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               rd_valid,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [LEN_W-1:0]   rd_len,
    input logic               rd_ready,
    input logic               wr_valid,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [LEN_W-1:0]   wr_len,
    input logic [BUS_W-1:0]   wr_data,
    input logic               wr_ready,
    input logic               dsc_req,
    input logic               dsc_ack,
    input logic [TOTAL_W-1:0] total_clr,
    input logic [TOTAL_W-1:0] total_bytes,
    input logic               done,
    input logic               src_done
);
    localparam int BEAT_B = BUS_W / 8;

    assert_rd_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_len != '0) && (rd_len <= LEN_W'(BEAT_B)));

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_len));

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    assert_wr_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != '0) && (wr_len <= LEN_W'(BEAT_B)));

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_len)
                                  && $stable(wr_data));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_req && !dsc_ack |=> dsc_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_src_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        src_done |-> done);

    assert_total_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (total_clr == '0) |=> (total_bytes - $past(total_bytes)) <= TOTAL_W'(BEAT_B));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid && !wr_valid && !dsc_req);
endmodule

bind dma_simple_engine dma_simple_engine_chk #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .LEN_W(LEN_W), .TOTAL_W(TOTAL_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_len(rd_len), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .wr_ready(wr_ready), .dsc_req(dsc_req), .dsc_ack(dsc_ack),
    .total_clr(total_clr), .total_bytes(total_bytes),
    .done(done), .src_done(src_done)
);

// File: tb/dma_simple_engine_tb.sv
module dma_simple_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W  = 64;
    localparam int ADDR_W = 12;
    localparam int SIZE_W = 10;
    localparam int LEN_W  = 4;
    localparam logic [127:0] PAT = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    typedef struct packed {
        logic [1:0]  mode;
        logic        incr;
        logic [11:0] sa;
        logic [9:0]  ss;
        logic [11:0] da;
        logic [9:0]  ds;
        logic        stall;
        logic [7:0]  rb;
        logic [7:0]  wb;
        logic [15:0] tot;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 12'h010, 10'd20, 12'h800, 10'd3,  1'b0, 8'd3, 8'd3, 16'd20},
        '{2'd0, 1'b1, 12'h013, 10'd8,  12'h905, 10'd0,  1'b1, 8'd1, 8'd1, 16'd8},
        '{2'd0, 1'b0, 12'h040, 10'd19, 12'h820, 10'd0,  1'b1, 8'd3, 8'd3, 16'd19},
        '{2'd1, 1'b1, 12'h000, 10'd5,  12'h840, 10'd13, 1'b0, 8'd0, 8'd2, 16'd13},
        '{2'd2, 1'b1, 12'h080, 10'd17, 12'h860, 10'd9,  1'b1, 8'd3, 8'd0, 16'd17},
        '{2'd3, 1'b1, 12'h020, 10'd9,  12'h880, 10'd0,  1'b0, 8'd2, 8'd2, 16'd9},
        '{2'd1, 1'b0, 12'h000, 10'd0,  12'h8C0, 10'd11, 1'b1, 8'd0, 8'd2, 16'd11}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              start = 1'b0, sg_mode = 1'b0, burst_incr = 1'b1;
    logic [1:0]        xfer_mode = 2'd0;
    logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0, nx_addr = '0;
    logic [SIZE_W-1:0] src_size = '0, dst_size = '0, nx_size = '0;
    logic              src_intr = 1'b1, dst_intr = 1'b1, nx_intr = 1'b1;
    logic [31:0]       total_clr = '0;
    logic              stall = 1'b0, clr_mon = 1'b0;
    logic              busy, rd_valid, rd_ready, wr_valid, wr_ready, dsc_req, dsc_ack;
    logic              done, src_done, dst_done;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [LEN_W-1:0]  rd_len, wr_len;
    logic [BUS_W-1:0]  rd_data, wr_data;
    logic [31:0]       total_bytes;
    logic [7:0]        cyc = '0;

    int errors = 0, checks = 0;
    int rbeats, wbeats, n_done, n_src, n_dst, n_dsc, max_rl, max_wl;
    logic rd_moved, wr_moved;
    logic [ADDR_W-1:0] rd_first, wr_first;
    logic rd_seen, wr_seen;
    logic [7:0] dmem [0:4095];

    function automatic logic [7:0] src_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ 8'hA5 ^ {4'h0, a[11:8]};
    endfunction

    always_comb begin
        for (int i = 0; i < BUS_W/8; i++) rd_data[8*i +: 8] = src_byte(rd_addr + ADDR_W'(i));
    end
    assign rd_ready = !stall || cyc[0];
    assign wr_ready = !stall || cyc[1];
    assign dsc_ack  = dsc_req;

    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (clr_mon) begin
            rbeats = 0; wbeats = 0; n_done = 0; n_src = 0; n_dst = 0; n_dsc = 0;
            max_rl = 0; max_wl = 0; rd_moved = 0; wr_moved = 0; rd_seen = 0; wr_seen = 0;
            for (int i = 0; i < 4096; i++) dmem[i] = 8'hEE;
        end else begin
            if (rd_valid && rd_ready) begin
                rbeats++;
                if (int'(rd_len) > max_rl) max_rl = int'(rd_len);
                if (!rd_seen) begin rd_first = rd_addr; rd_seen = 1; end
                else if (rd_addr != rd_first) rd_moved = 1;
            end
            if (wr_valid && wr_ready) begin
                wbeats++;
                if (int'(wr_len) > max_wl) max_wl = int'(wr_len);
                if (!wr_seen) begin wr_first = wr_addr; wr_seen = 1; end
                else if (wr_addr != wr_first) wr_moved = 1;
                for (int i = 0; i < int'(wr_len); i++)
                    dmem[wr_addr + ADDR_W'(i)] = wr_data[8*i +: 8];
            end
            if (done) n_done++;
            if (src_done) n_src++;
            if (dst_done) n_dst++;
            if (dsc_req && dsc_ack) n_dsc++;
        end
    end

    dma_simple_engine #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TOTAL_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sg_mode(sg_mode), .xfer_mode(xfer_mode),
        .burst_incr(burst_incr), .src_addr(src_addr), .src_size(src_size), .src_intr(src_intr),
        .dst_addr(dst_addr), .dst_size(dst_size), .dst_intr(dst_intr), .fill_pattern(PAT),
        .busy(busy), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_len(wr_len), .wr_data(wr_data), .wr_ready(wr_ready), .dsc_req(dsc_req),
        .dsc_ack(dsc_ack), .dsc_addr(nx_addr), .dsc_size(nx_size), .dsc_intr(nx_intr),
        .total_clr(total_clr), .total_bytes(total_bytes), .done(done),
        .src_done(src_done), .dst_done(dst_done));

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_mon = 1'b1; total_clr = '1;
        @(negedge clk);
        clr_mon = 1'b0; total_clr = '0;
    endtask

    task automatic launch();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 2000 && n_done == 0; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    logic finished = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!busy && !rd_valid && !wr_valid && !dsc_req, "R12 reset quiet", busy, 0);
        check(total_bytes == 0 && !done && !src_done && !dst_done, "R12 reset total/pulses", total_bytes, 0);
        rst_n = 1'b1;
        clear_all();

        for (int v = 0; v < NV; v++) begin
            vec_t e = VECS[v];
            int cnt, span, bad;
            clear_all();
            xfer_mode = e.mode; burst_incr = e.incr; sg_mode = 1'b0;
            src_addr = e.sa; src_size = e.ss; dst_addr = e.da; dst_size = e.ds;
            src_intr = 1'b1; dst_intr = 1'b1; stall = e.stall;
            launch();
            wait_done();
            stall = 1'b0;
            check(total_bytes == 32'(e.tot), $sformatf("R10 vec%0d total", v), total_bytes, e.tot);
            check(rbeats == int'(e.rb), $sformatf("R3 R5 vec%0d read beats", v), rbeats, e.rb);
            check(wbeats == int'(e.wb), $sformatf("R4 R5 vec%0d write beats", v), wbeats, e.wb);
            check(max_rl <= 8 && max_wl <= 8, $sformatf("R3 vec%0d beat cap", v), max_rl, 8);
            check(n_done == 1 && n_src == 1, $sformatf("R11 vec%0d done/src_done", v), n_done, 1);
            check(n_dst == ((e.mode == 2'd2) ? 0 : 1), $sformatf("R9 vec%0d dst_done", v), n_dst, 1);
            if (e.rb > 1) check(rd_moved == e.incr, $sformatf("R2 vec%0d read addr step", v), rd_moved, e.incr);
            if (e.wb > 1) check(wr_moved == e.incr, $sformatf("R2 vec%0d write addr step", v), wr_moved, e.incr);
            // R1 R4 R6: destination image
            cnt  = (e.mode == 2'd1) ? int'(e.ds) : int'(e.ss);
            span = e.incr ? cnt : ((cnt < 8) ? cnt : 8);
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                logic [7:0] ex;
                if (e.mode == 2'd2 || i >= span) ex = 8'hEE;
                else if (e.mode == 2'd1) ex = PAT[8*(i%8) +: 8];
                else ex = src_byte(e.sa + ADDR_W'(i));
                if (dmem[e.da + ADDR_W'(i)] != ex) bad++;
            end
            check(bad == 0, $sformatf("R1 R4 R6 vec%0d memory image", v), bad, 0);
        end

        // R11: zero length completes on first edge, no accesses, no src_done when intr clear
        clear_all();
        xfer_mode = 2'd0; burst_incr = 1'b1; src_size = '0; src_intr = 1'b0;
        launch();
        check(done && !busy && !src_done, "R11 zero-size done", done, 1);
        repeat (3) @(negedge clk);
        check(rbeats == 0 && wbeats == 0 && n_done == 1 && n_src == 0, "R11 zero-size quiet", rbeats + wbeats, 0);

        // R7 R8 R9: scatter-gather with a split destination; mode/burst inputs ignored
        clear_all();
        sg_mode = 1'b1; xfer_mode = 2'd2; burst_incr = 1'b0;
        src_addr = 12'h100; src_size = 10'd20; src_intr = 1'b1;
        dst_addr = 12'hA00; dst_size = 10'd6; dst_intr = 1'b1;
        nx_addr = 12'hA40; nx_size = 10'd14; nx_intr = 1'b1; stall = 1'b1;
        launch();
        wait_done();
        stall = 1'b0;
        check(n_dsc == 1, "R8 one descriptor request", n_dsc, 1);
        check(wbeats == 4, "R8 split writes", wbeats, 4);
        check(n_dst == 2, "R9 two dst_done", n_dst, 2);
        begin
            int bad = 0;
            for (int i = 0; i < 6; i++)  if (dmem[12'hA00 + i] != src_byte(12'h100 + ADDR_W'(i))) bad++;
            for (int i = 6; i < 20; i++) if (dmem[12'hA40 + i - 6] != src_byte(12'h100 + ADDR_W'(i))) bad++;
            if (dmem[12'hA06] != 8'hEE) bad++;
            check(bad == 0, "R7 R8 sg memory image", bad, 0);
        end
        check(total_bytes == 20, "R10 sg total", total_bytes, 20);
        sg_mode = 1'b0;

        // R12: start while busy is ignored
        clear_all();
        xfer_mode = 2'd0; burst_incr = 1'b1; src_addr = 12'h010; src_size = 10'd24;
        dst_addr = 12'hB00; dst_size = '0; stall = 1'b1;
        launch();
        repeat (3) @(negedge clk);
        xfer_mode = 2'd1; dst_addr = 12'hC00; dst_size = 10'd100; src_size = 10'd100;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        stall = 1'b0;
        repeat (5) @(negedge clk);
        check(total_bytes == 24 && n_done == 1, "R12 start ignored total", total_bytes, 24);
        check(dmem[12'hC00] == 8'hEE && wbeats == 3, "R12 start ignored writes", wbeats, 3);

        // R10: partial write-one-to-clear
        @(negedge clk); total_clr = 32'h0000_0008;
        @(negedge clk); total_clr = '0;
        check(total_bytes == 32'h10, "R10 partial clear", total_bytes, 32'h10);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule